// File: doc/BRIEF.md
# Codec-Side Serial Audio Link Framer

This block sits at the codec end of a bidirectional, time-division serial audio link that runs on a single bit clock. Each frame is opened by a rising edge on the frame-sync input and carries a 16-bit tag slot followed by twelve 20-bit slots, most significant bit first. Inbound, the block turns the tag, the control slots and the two playback slots into one-cycle strobes on a register port and on two playback sample ports. Outbound, it builds the status tag, the echo of a pending register read with its data, the active-low sample requests and the two record samples, and shifts them out.

A register read decoded in one frame is answered in the following frame: the core returns the read data combinationally in the strobe cycle, the block holds it, and it places index and data in slots 1 and 2 of the next outbound frame. Samples are 18 bits wide and sit left-justified in their 20-bit slots. Inbound data is captured on the falling edge of the bit clock. Outbound data changes on the rising edge.

Top module: `aclink_codec_if`

## Requirements
- R1: A frame starts when `frame_sync_i`, sampled on a falling clock edge, is seen high after being low. Outbound frame bit 0 appears on `ser_tx_o` after the next rising edge, and each following rising edge presents the next bit.
- R2: Inbound frame bit 0 is the value of `ser_rx_i` sampled on the falling edge that follows the falling edge on which the sync rise was seen. Later bits follow one per falling edge.
- R3: A frame is laid out as a 16-bit slot 0 followed by 20-bit slots 1 to 12, 256 bits in total, each slot sent most significant bit first.
- R4: `wr_en_o` pulses for one cycle, with `wr_addr_o` = inbound slot1[18:12] and `wr_data_o` = slot2[19:4], only when inbound tag bits 15, 14 and 13 are all 1 and slot1[19] is 1 (write).
- R5: `rd_en_o` pulses for one cycle, with `rd_addr_o` = slot1[18:12], when tag bits 15 and 14 are 1 and slot1[19] is 0 (read). `rd_data_i` is taken in that same cycle.
- R6: In the next outbound frame after a read, tag bits 14 and 13 are 1, slot1[18:12] holds the read index and slot2[19:4] holds the read data. In any frame with no read pending, those tag bits, that index field and slot 2 are all zero.
- R7: `play_l_vld_o` pulses with `play_l_o` = inbound slot3[19:2] when tag bits 15 and 12 are set. `play_r_vld_o` pulses with `play_r_o` = slot4[19:2] when tag bits 15 and 11 are set. Slot bits 1:0 are dropped.
- R8: Outbound tag bit 15 equals `ready_i`, and bits 12 and 11 equal `rec_l_vld_i` and `rec_r_vld_i`, all sampled at frame start. Slot 3 carries {`rec_l_i`, 2'b00} and slot 4 carries {`rec_r_i`, 2'b00} when the matching valid is high, and zero otherwise.
- R9: Outbound slot1[11] is the inverse of `need_l_i` and slot1[10] is the inverse of `need_r_i`, both sampled at frame start.
- R10: An inbound frame whose tag bit 15 is 0 produces no write, read or playback strobe.
- R11: All other outbound bits are zero: tag bits 10:0, slot1[19], slot1[9:0], slot2[3:0] and slots 5 to 12. `ser_tx_o` is zero before the first frame start.
- R12: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | Frame sync from the controller |
| ser_rx_i | input | 1 | Serial stream from the controller |
| ser_tx_o | output | 1 | Serial stream to the controller |
| ready_i | input | 1 | Core ready flag for the status tag |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 7 | Register write index |
| wr_data_o | output | 16 | Register write data |
| rd_en_o | output | 1 | Register read strobe |
| rd_addr_o | output | 7 | Register read index |
| rd_data_i | input | 16 | Read data, valid in the `rd_en_o` cycle |
| play_l_vld_o | output | 1 | Left playback sample strobe |
| play_l_o | output | 18 | Left playback sample |
| play_r_vld_o | output | 1 | Right playback sample strobe |
| play_r_o | output | 18 | Right playback sample |
| rec_l_vld_i | input | 1 | Left record sample valid |
| rec_l_i | input | 18 | Left record sample |
| rec_r_vld_i | input | 1 | Right record sample valid |
| rec_r_i | input | 18 | Right record sample |
| need_l_i | input | 1 | Core wants a left playback sample next frame |
| need_r_i | input | 1 | Core wants a right playback sample next frame |

## Verification
The bench builds the block with its default parameters: a 16-bit tag, 20-bit slots, 7-bit register indices, 16-bit register data, 18-bit samples and a 256-bit frame. At this size a sweep of 64 frames covers every combination of the five inbound tag flags with the read/write bit. Each frame also varies the ready, request and record-valid inputs, and every outbound frame is compared bit for bit against a model that includes the pending read from the previous frame. Nonzero filler in the dropped sample bits and in slots 5 to 12 exposes any leak of reserved inbound content.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int unsigned TAG_W      = 16;
  localparam int unsigned SLOT_W     = 20;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned SMP_W      = 18;
  localparam int unsigned FRAME_BITS = 256;
  localparam int unsigned NUM_CH     = 2;  // index 0 = left, 1 = right
endpackage

// File: rtl/aclink_timing.sv
module aclink_timing #(
  parameter int unsigned FRAME_BITS = aclink_pkg::FRAME_BITS,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             rx_i,
  output logic             start_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rx_bit_o
);
  logic sync_n_q, rx_n_q, sync_p_q;
  logic [CNT_W-1:0] cnt_q;

  // falling-edge capture of the inbound pins
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_n_q <= 1'b0;
      rx_n_q   <= 1'b0;
    end else begin
      sync_n_q <= sync_i;
      rx_n_q   <= rx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_p_q <= 1'b0;
    else         sync_p_q <= sync_n_q;
  end

  assign start_o = sync_n_q & ~sync_p_q;

  // cnt = index of the outbound bit driven at this rising edge; FRAME_BITS = idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= CNT_W'(FRAME_BITS);
    else if (start_o)                         cnt_q <= CNT_W'(1);
    else if (cnt_q != CNT_W'(FRAME_BITS))     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o    = cnt_q;
  assign rx_bit_o = rx_n_q;

  assert_start_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/aclink_deframe.sv
module aclink_deframe
  import aclink_pkg::*;
#(
  parameter int unsigned FRAME_BITS = aclink_pkg::FRAME_BITS,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1),
  localparam int unsigned RX_BITS   = TAG_W + 4 * SLOT_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [CNT_W-1:0]               cnt_i,
  input  logic                           bit_i,
  output logic                           wr_en_o,
  output logic                           rd_en_o,
  output logic [ADDR_W-1:0]              addr_o,
  output logic [REG_W-1:0]               data_o,
  output logic [NUM_CH-1:0]              play_vld_o,
  output logic [NUM_CH-1:0][SMP_W-1:0]   play_smp_o
);
  // full frame prefix = {sh_q, bit_i}; MSB is frame bit 0
  logic [RX_BITS-2:0] sh_q;
  logic shift_en, done;

  assign shift_en = !start_i && (cnt_i >= CNT_W'(1)) && (cnt_i <= CNT_W'(RX_BITS));
  assign done     = shift_en && (cnt_i == CNT_W'(RX_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[RX_BITS-3:0], bit_i};
  end

  localparam int unsigned T_VALID = RX_BITS - 2;
  localparam int unsigned S1_HI   = RX_BITS - TAG_W - 2;
  localparam int unsigned S2_HI   = S1_HI - SLOT_W;

  logic f_valid, f_addr, f_data, f_wr;
  logic [NUM_CH-1:0] f_play;
  logic [ADDR_W-1:0] f_idx;
  logic [REG_W-1:0]  f_wdata;
  logic [NUM_CH-1:0][SMP_W-1:0] f_smp;

  assign f_valid = sh_q[T_VALID];
  assign f_addr  = sh_q[T_VALID-1];
  assign f_data  = sh_q[T_VALID-2];
  assign f_wr    = sh_q[S1_HI];
  assign f_idx   = sh_q[S1_HI-1 -: ADDR_W];
  assign f_wdata = sh_q[S2_HI -: REG_W];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_play
    localparam int unsigned SS_HI = S2_HI - (ch + 1) * SLOT_W;
    assign f_play[ch] = sh_q[T_VALID-3-ch];
    assign f_smp[ch]  = sh_q[SS_HI -: SMP_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        play_vld_o[ch] <= 1'b0;
        play_smp_o[ch] <= '0;
      end else begin
        play_vld_o[ch] <= done && f_valid && f_play[ch];
        if (done && f_valid && f_play[ch]) play_smp_o[ch] <= f_smp[ch];
      end
    end

    assert_play_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      play_vld_o[ch] |=> !play_vld_o[ch]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o <= 1'b0;
      rd_en_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      wr_en_o <= done && f_valid && f_addr && f_data && f_wr;
      rd_en_o <= done && f_valid && f_addr && !f_wr;
      if (done && f_valid && f_addr) addr_o <= f_idx;
      if (done && f_valid && f_addr && f_data && f_wr) data_o <= f_wdata;
    end
  end

  assert_wr_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  assert_rd_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
endmodule

// File: rtl/aclink_readback.sv
module aclink_readback
  import aclink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic              pend_v_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [REG_W-1:0]  pend_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_o    <= 1'b0;
      pend_addr_o <= '0;
      pend_data_o <= '0;
    end else if (rd_en_i) begin
      pend_v_o    <= 1'b1;
      pend_addr_o <= rd_addr_i;
      pend_data_o <= rd_data_i;
    end else if (start_i) begin
      pend_v_o    <= 1'b0;  // consumed by the frame being loaded now
    end
  end

  assert_pend_consumed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pend_v_o);
endmodule

// File: rtl/aclink_framer.sv
module aclink_framer
  import aclink_pkg::*;
#(
  parameter int unsigned FRAME_BITS = aclink_pkg::FRAME_BITS,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1),
  localparam int unsigned TX_BITS   = TAG_W + 4 * SLOT_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic                         ready_i,
  input  logic                         pend_v_i,
  input  logic [ADDR_W-1:0]            pend_addr_i,
  input  logic [REG_W-1:0]             pend_data_i,
  input  logic [NUM_CH-1:0]            need_i,
  input  logic [NUM_CH-1:0]            rec_vld_i,
  input  logic [NUM_CH-1:0][SMP_W-1:0] rec_smp_i,
  output logic                         tx_o
);
  logic [TAG_W-1:0]              tag;
  logic [SLOT_W-1:0]             s1, s2;
  logic [NUM_CH-1:0][SLOT_W-1:0] rec_slot;
  logic [TX_BITS-1:0]            frame, sh_q;

  assign tag = {ready_i, pend_v_i, pend_v_i, rec_vld_i[0], rec_vld_i[1], {(TAG_W-5){1'b0}}};
  // request bits are active low
  assign s1  = {1'b0, pend_v_i ? pend_addr_i : {ADDR_W{1'b0}}, ~need_i[0], ~need_i[1],
                {(SLOT_W-ADDR_W-3){1'b0}}};
  assign s2  = pend_v_i ? {pend_data_i, {(SLOT_W-REG_W){1'b0}}} : '0;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_rec
    assign rec_slot[ch] = rec_vld_i[ch] ? {rec_smp_i[ch], {(SLOT_W-SMP_W){1'b0}}} : '0;
  end

  assign frame = {tag, s1, s2, rec_slot[0], rec_slot[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_o <= 1'b0;
      sh_q <= '0;
    end else if (start_i) begin
      tx_o <= frame[TX_BITS-1];
      sh_q <= {frame[TX_BITS-2:0], 1'b0};
    end else if (cnt_i < CNT_W'(FRAME_BITS)) begin
      tx_o <= sh_q[TX_BITS-1];
      sh_q <= {sh_q[TX_BITS-2:0], 1'b0};
    end else begin
      tx_o <= 1'b0;
    end
  end

  assert_ready_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (tx_o == $past(ready_i)));
  assert_reserved_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_i >= CNT_W'(TX_BITS)) |=> !tx_o);
endmodule

// File: rtl/aclink_codec_if.sv
module aclink_codec_if
  import aclink_pkg::*;
#(
  parameter int unsigned FRAME_BITS = aclink_pkg::FRAME_BITS,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_sync_i,
  input  logic              ser_rx_i,
  output logic              ser_tx_o,
  input  logic              ready_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic              play_l_vld_o,
  output logic [SMP_W-1:0]  play_l_o,
  output logic              play_r_vld_o,
  output logic [SMP_W-1:0]  play_r_o,
  input  logic              rec_l_vld_i,
  input  logic [SMP_W-1:0]  rec_l_i,
  input  logic              rec_r_vld_i,
  input  logic [SMP_W-1:0]  rec_r_i,
  input  logic              need_l_i,
  input  logic              need_r_i
);
  logic                         start, rx_bit;
  logic [CNT_W-1:0]             cnt;
  logic [ADDR_W-1:0]            ctl_addr;
  logic [NUM_CH-1:0]            play_vld;
  logic [NUM_CH-1:0][SMP_W-1:0] play_smp;
  logic                         pend_v;
  logic [ADDR_W-1:0]            pend_addr;
  logic [REG_W-1:0]             pend_data;

  aclink_timing #(.FRAME_BITS(FRAME_BITS)) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (frame_sync_i),
    .rx_i     (ser_rx_i),
    .start_o  (start),
    .cnt_o    (cnt),
    .rx_bit_o (rx_bit)
  );

  aclink_deframe #(.FRAME_BITS(FRAME_BITS)) u_deframe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .cnt_i      (cnt),
    .bit_i      (rx_bit),
    .wr_en_o    (wr_en_o),
    .rd_en_o    (rd_en_o),
    .addr_o     (ctl_addr),
    .data_o     (wr_data_o),
    .play_vld_o (play_vld),
    .play_smp_o (play_smp)
  );

  assign wr_addr_o    = ctl_addr;
  assign rd_addr_o    = ctl_addr;
  assign play_l_vld_o = play_vld[0];
  assign play_r_vld_o = play_vld[1];
  assign play_l_o     = play_smp[0];
  assign play_r_o     = play_smp[1];

  aclink_readback u_readback (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .rd_en_i     (rd_en_o),
    .rd_addr_i   (ctl_addr),
    .rd_data_i   (rd_data_i),
    .pend_v_o    (pend_v),
    .pend_addr_o (pend_addr),
    .pend_data_o (pend_data)
  );

  aclink_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cnt_i       (cnt),
    .ready_i     (ready_i),
    .pend_v_i    (pend_v),
    .pend_addr_i (pend_addr),
    .pend_data_i (pend_data),
    .need_i      ({need_r_i, need_l_i}),
    .rec_vld_i   ({rec_r_vld_i, rec_l_vld_i}),
    .rec_smp_i   ({rec_r_i, rec_l_i}),
    .tx_o        (ser_tx_o)
  );
endmodule

// File: tb/sim_aclink_codec_if.sv
module sim_aclink_codec_if;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, sync, rx, tx, ready;
  logic        wr_en, rd_en, pl_v, pr_v;
  logic [6:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic [17:0] pl, pr, rec_l, rec_r;
  logic        rec_l_v, rec_r_v, need_l, need_r;

  function automatic logic [15:0] rd_fn(input logic [6:0] a);
    return {a, a ^ 7'h55, 2'b10};
  endfunction
  assign rd_data = rd_fn(rd_addr);

  aclink_codec_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_sync_i(sync), .ser_rx_i(rx), .ser_tx_o(tx),
    .ready_i(ready), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .play_l_vld_o(pl_v), .play_l_o(pl), .play_r_vld_o(pr_v), .play_r_o(pr),
    .rec_l_vld_i(rec_l_v), .rec_l_i(rec_l), .rec_r_vld_i(rec_r_v), .rec_r_i(rec_r),
    .need_l_i(need_l), .need_r_i(need_r)
  );

  int checks = 0, errors = 0;
  int wr_n, rd_n, pl_n, pr_n, tx_ones;
  logic [6:0]  seen_wa, seen_ra;
  logic [15:0] seen_wd;
  logic [17:0] seen_pl, seen_pr;

  task automatic check(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin wr_n++; seen_wa = wr_addr; seen_wd = wr_data; end
    if (rd_en) begin rd_n++; seen_ra = rd_addr; end
    if (pl_v)  begin pl_n++; seen_pl = pl; end
    if (pr_v)  begin pr_n++; seen_pr = pr; end
    if (tx)    tx_ones++;
  end

  task automatic clear_mon();
    wr_n = 0; rd_n = 0; pl_n = 0; pr_n = 0; tx_ones = 0;
  endtask

  logic        pv;
  logic [6:0]  pa;
  logic [15:0] pd;

  task automatic run_frame(input int i);
    logic v, a, d, l, r, rw;
    logic [6:0]   addr;
    logic [15:0]  wdat;
    logic [17:0]  spl, spr;
    logic [255:0] fr, got, exp;
    {rw, r, l, d, a, v} = 6'(i);
    addr = 7'(i * 37 + 5);
    wdat = 16'(i * 4951) ^ 16'hC0DE;
    spl  = 18'(i * 9001 + 1);
    spr  = 18'(i * 313) ^ 18'h15555;
    fr   = {v, a, d, l, r, 11'h000, rw, addr, 12'h000, wdat, 4'h0,
            spl, 2'b11, spr, 2'b01, {5{32'hDEADBEEF}}};
    got  = '0;
    for (int k = 0; k < 256; k++) begin
      @(posedge clk); #1;
      if (k == 0) begin
        clear_mon();
        ready   = i[1] ^ i[2];
        need_l  = i[2];
        need_r  = i[3] ^ i[0];
        rec_l_v = i[4] ^ i[1];
        rec_r_v = i[5] ^ i[3];
        rec_l   = 18'(i * 12345 + 7);
        rec_r   = 18'(i * 777) ^ 18'h2AAAA;
      end
      sync = (k < 16);
      rx   = (k == 0) ? 1'b0 : fr[256-k];
      @(negedge clk);
      if (k >= 1) got[256-k] = tx;
    end
    exp = {ready, pv, pv, rec_l_v, rec_r_v, 11'h000,
           1'b0, pv ? pa : 7'h00, ~need_l, ~need_r, 10'h000,
           pv ? {pd, 4'h0} : 20'h0,
           rec_l_v ? {rec_l, 2'b00} : 20'h0,
           rec_r_v ? {rec_r, 2'b00} : 20'h0,
           160'h0};
    check(got[255:240] == exp[255:240], $sformatf("R8 R6 R1 tag slot frame %0d", i), got[255:240], exp[255:240]);
    check(got[239:220] == exp[239:220], $sformatf("R9 R6 R3 slot1 frame %0d", i), got[239:220], exp[239:220]);
    check(got[219:200] == exp[219:200], $sformatf("R6 slot2 frame %0d", i), got[219:200], exp[219:200]);
    check(got[199:160] == exp[199:160], $sformatf("R8 record slots frame %0d", i), got[199:160], exp[199:160]);
    check(got[159:0] == 160'h0, $sformatf("R11 slots 5-12 frame %0d", i), got[159:0], 160'h0);
    // write strobe (R4; R10 when v = 0)
    check(wr_n == int'(v & a & d & rw), $sformatf("R4 R10 write count frame %0d", i), wr_n, v & a & d & rw);
    if (v & a & d & rw)
      check({seen_wa, seen_wd} == {addr, wdat}, $sformatf("R4 write fields frame %0d", i),
            {seen_wa, seen_wd}, {addr, wdat});
    check(rd_n == int'(v & a & ~rw), $sformatf("R5 R10 read count frame %0d", i), rd_n, v & a & ~rw);
    if (v & a & ~rw)
      check(seen_ra == addr, $sformatf("R5 read index frame %0d", i), seen_ra, addr);
    check(pl_n == int'(v & l), $sformatf("R7 R10 left strobe frame %0d", i), pl_n, v & l);
    if (v & l) check(seen_pl == spl, $sformatf("R7 R2 left sample frame %0d", i), seen_pl, spl);
    check(pr_n == int'(v & r), $sformatf("R7 R10 right strobe frame %0d", i), pr_n, v & r);
    if (v & r) check(seen_pr == spr, $sformatf("R7 R2 right sample frame %0d", i), seen_pr, spr);
    pv = v & a & ~rw;
    pa = addr;
    pd = rd_fn(addr);
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync = 1'b0; rx = 1'b0; ready = 1'b0;
    rec_l_v = 1'b0; rec_r_v = 1'b0; rec_l = '0; rec_r = '0;
    need_l = 1'b0; need_r = 1'b0;
    pv = 1'b0; pa = '0; pd = '0;
    clear_mon();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({tx, wr_en, rd_en, pl_v, pr_v} == 5'b0, "R12 strobes in reset", {tx, wr_en, rd_en, pl_v, pr_v}, 0);
    check({wr_addr, wr_data, pl, pr} == '0, "R12 data outputs in reset", {wr_addr, wr_data, pl, pr}, 0);
    @(posedge clk); #1; rst_n = 1'b1; rx = 1'b1;
    repeat (300) @(posedge clk);
    @(negedge clk);
    check(tx_ones == 0, "R11 idle output before first frame", tx_ones, 0);
    check(wr_n + rd_n + pl_n + pr_n == 0, "R10 no strobes before first frame", wr_n + rd_n + pl_n + pr_n, 0);
    for (int i = 0; i <= 64; i++) run_frame(i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule